// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a simple single-request host bus and an external 128K x 8 static RAM that has no clock. The RAM has two chip selects of opposite polarity, an active-low write strobe and an active-low output enable. The host raises a request with a write flag, an address and write data, and holds them until the controller pulses done. For a read, the byte returned is available on the read-data output when done pulses. The controller turns every analog timing rule of the RAM into a whole number of system clock cycles at elaboration time. It does this from the clock period and a speed-grade parameter, rounding each nanosecond figure up to whole cycles.

Each access runs a fixed sequence: a setup cycle, a strobe phase and a turnaround phase. In the setup cycle the address is applied and the RAM is selected, with both strobes inactive. In the strobe phase either the write strobe or the output enable is low. In the turnaround phase everything is released together and the RAM is given time to stop driving the shared data lines. A retention input parks the RAM in its lowest-power state. While retention is active, host requests are held off. Once retention ends, the controller waits a further recovery interval before it starts an access.

Top module: `sram_ctl`

## Requirements
- R1: While reset is low and after it is released, the RAM is deselected (mem_cs1_n = 1, mem_cs2 = 0), mem_we_n = 1, mem_oe_n = 1, mem_dq_oe = 0 and done = 0.
- R2: A write (wr = 1) starts with exactly one setup cycle, in which the RAM is selected and mem_we_n and mem_oe_n are both 1. It continues with mem_we_n = 0 and mem_dq_oe = 1 for WR_N cycles, where WR_N is the larger of the write-pulse and data-setup minima in cycles (3 at the defaults: fast grade, 10 ns clock). It ends with a turnaround, and done is high on the last turnaround cycle, 6 clock edges after the request was first seen at the defaults.
- R3: A read (wr = 0) has one setup cycle, then mem_oe_n = 0 for RD_N cycles, where RD_N is the larger of the address-access and enable-access maxima in cycles (3 at the defaults). The byte on mem_dq_in at the end of the last such cycle appears on rdata, done follows 6 edges after the request, and rdata keeps that byte until the next read completes.
- R4: mem_we_n and mem_oe_n are never low together, and mem_dq_oe is high only while mem_we_n is low and the RAM is selected.
- R5: After mem_oe_n returns high, mem_dq_oe stays low for more than HIZ_N full cycles. HIZ_N is the larger of the enable-release and select-release high-impedance maxima in cycles (2 at the defaults).
- R6: The parameter FAST_GRADE = 0 selects the slow timing set. At a 10 ns clock this gives a write strobe of 4 cycles with done 7 edges after the request, and a read enable of 5 cycles with done 8 edges after the request.
- R7: While retain is 1, the RAM stays deselected with mem_oe_n = 1, and a pending request is neither started nor answered. Retain wins over a request that arrives in the same cycle. After retain falls, the select is first asserted on the 5th rising edge at the defaults: one edge to leave retention, 3 recovery cycles, one edge to accept.
- R8: The full 17-bit host address is driven on mem_addr, and it stays stable for the whole time the RAM is selected.
- R9: done is a single-cycle pulse, and one pulse is given for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, held until done |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 17 | Host byte address |
| wdata | input | 8 | Byte to write |
| retain | input | 1 | Enter and hold low-power retention |
| done | output | 1 | One-cycle access completion pulse |
| rdata | output | 8 | Last byte read |
| mem_addr | output | 17 | RAM address lines |
| mem_cs1_n | output | 1 | RAM select, active low |
| mem_cs2 | output | 1 | RAM select, active high |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_out | output | 8 | Data driven toward the RAM |
| mem_dq_in | input | 8 | Data returned from the RAM |
| mem_dq_oe | output | 1 | Drive enable for the shared data lines |

## Verification
The request is raised just after a falling edge, and the bench counts rising edges until done is seen high at a falling edge. That count must be 6 at the defaults, or 7 or 8 for the slow instance, and rdata is compared in that same done cycle. Monitors sampling at every falling edge measure how many cycles each strobe stays low, how many cycles pass between the enable release and the next drive, and which address is presented at select time. The tasks compare these against the cycle counts the requirements give. For retention, the bench counts edges from the fall of retain to the first select, and expects exactly 5.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_WR,
      ST_RD,
      ST_TURN,
      ST_RET,
      ST_RECOV
   } sram_st_e;

   // nanosecond figures of one speed grade
   typedef struct packed {
      int cycle_ns;     // minimum read and write cycle
      int wpulse_ns;    // minimum write strobe width
      int dsetup_ns;    // minimum data setup before write end
      int aacc_ns;      // maximum address to data
      int oeacc_ns;     // maximum enable to data
      int oehiz_ns;     // maximum drive after enable release
      int cshiz_ns;     // maximum drive after select release
   } sram_tim_t;

   localparam sram_tim_t TIM_FAST = '{cycle_ns: 30, wpulse_ns: 22, dsetup_ns: 18,
                                      aacc_ns: 30, oeacc_ns: 12, oehiz_ns: 8, cshiz_ns: 15};
   localparam sram_tim_t TIM_SLOW = '{cycle_ns: 45, wpulse_ns: 35, dsetup_ns: 20,
                                      aacc_ns: 45, oeacc_ns: 15, oehiz_ns: 15, cshiz_ns: 20};

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // ceiling division; any nonzero figure yields at least one cycle
   function automatic int ns2cyc(input int ns, input int clk_ns);
      if (ns <= 0) return 0;
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_dp.sv
module sram_ctl_dp #(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] dq_in,
   output logic              wr_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rdata_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         wr_q    <= wr_i;
         addr_q  <= addr_i;
         wdata_q <= wdata_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (capture) begin
         rdata_q <= dq_in;
      end
   end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
   import sram_ctl_pkg::*;
#(
   parameter int CLK_NS     = 10,
   parameter bit FAST_GRADE = 1'b1,
   parameter int ADDR_W     = 17,
   parameter int DATA_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              retain,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs1_n,
   output logic              mem_cs2,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_out,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              mem_dq_oe
);

   localparam sram_tim_t TIM = FAST_GRADE ? TIM_FAST : TIM_SLOW;
   localparam int WR_N  = ns2cyc(imax(TIM.wpulse_ns, TIM.dsetup_ns), CLK_NS);
   localparam int RD_N  = ns2cyc(imax(TIM.aacc_ns, TIM.oeacc_ns), CLK_NS);
   localparam int HIZ_N = ns2cyc(imax(TIM.oehiz_ns, TIM.cshiz_ns), CLK_NS);
   localparam int CYC_N = ns2cyc(TIM.cycle_ns, CLK_NS);
   localparam int TW_N  = imax(imax(HIZ_N, CYC_N - 1 - WR_N), 1);
   localparam int TR_N  = imax(imax(HIZ_N, CYC_N - 1 - RD_N), 1);
   localparam int REC_N = imax(CYC_N, 1);
   localparam int MAX_N = imax(imax(WR_N, RD_N), imax(imax(TW_N, TR_N), REC_N));
   localparam int CNT_W = $clog2(MAX_N + 1);

   if (CLK_NS < 1) begin : g_bad_clk
      $error("sram_ctl: CLK_NS must be at least 1");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("sram_ctl: address and data widths must be positive");
   end

   sram_st_e         st_q, st_d;
   logic             ld, zero, accept, capture, sel, wr_q;
   logic [CNT_W-1:0] ld_val;

   sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld),
      .load_val (ld_val),
      .zero     (zero)
   );

   sram_ctl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (accept),
      .capture (capture),
      .wr_i    (wr),
      .addr_i  (addr),
      .wdata_i (wdata),
      .dq_in   (mem_dq_in),
      .wr_q    (wr_q),
      .addr_q  (mem_addr),
      .wdata_q (mem_dq_out),
      .rdata_q (rdata)
   );

   always_comb begin
      st_d    = st_q;
      ld      = 1'b0;
      ld_val  = '0;
      accept  = 1'b0;
      capture = 1'b0;
      done    = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (retain) begin
               st_d = ST_RET;
            end else if (req) begin
               st_d   = ST_SETUP;
               accept = 1'b1;
            end
         end
         ST_SETUP: begin
            ld = 1'b1;
            if (wr_q) begin
               st_d   = ST_WR;
               ld_val = CNT_W'(WR_N - 1);
            end else begin
               st_d   = ST_RD;
               ld_val = CNT_W'(RD_N - 1);
            end
         end
         ST_WR: begin
            if (zero) begin
               st_d   = ST_TURN;
               ld     = 1'b1;
               ld_val = CNT_W'(TW_N - 1);
            end
         end
         ST_RD: begin
            if (zero) begin
               st_d    = ST_TURN;
               ld      = 1'b1;
               ld_val  = CNT_W'(TR_N - 1);
               capture = 1'b1;
            end
         end
         ST_TURN: begin
            if (zero) begin
               st_d = ST_IDLE;
               done = 1'b1;
            end
         end
         ST_RET: begin
            if (!retain) begin
               st_d   = ST_RECOV;
               ld     = 1'b1;
               ld_val = CNT_W'(REC_N - 1);
            end
         end
         ST_RECOV: begin
            if (retain) begin
               st_d = ST_RET;
            end else if (zero) begin
               st_d = ST_IDLE;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
      end else begin
         st_q <= st_d;
      end
   end

   // strobes decode straight from the state register
   assign sel       = (st_q == ST_SETUP) || (st_q == ST_WR) || (st_q == ST_RD);
   assign mem_cs1_n = !sel;
   assign mem_cs2   = sel;
   assign mem_we_n  = (st_q != ST_WR);
   assign mem_oe_n  = (st_q != ST_RD);
   assign mem_dq_oe = (st_q == ST_WR);

   // ---------------- checking logic ----------------
   logic [CNT_W:0] we_len_q;
   logic [CNT_W:0] oe_gap_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         we_len_q <= '0;
         oe_gap_q <= (CNT_W+1)'(HIZ_N);
      end else begin
         if (!mem_we_n) begin
            if (we_len_q != '1) we_len_q <= we_len_q + 1'b1;
         end else begin
            we_len_q <= '0;
         end
         if (!mem_oe_n) begin
            oe_gap_q <= '0;
         end else if (oe_gap_q < (CNT_W+1)'(HIZ_N)) begin
            oe_gap_q <= oe_gap_q + 1'b1;
         end
      end
   end

   // R4
   rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_we_n && !mem_oe_n));

   // R4
   drive_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (!mem_we_n && !mem_cs1_n && mem_cs2));

   // R5
   bus_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (oe_gap_q >= (CNT_W+1)'(HIZ_N)));

   // R2
   we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_len_q >= (CNT_W+1)'(WR_N)));

   // R7
   ret_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (retain && mem_cs1_n) |=> (!retain || (mem_cs1_n && !mem_cs2 && mem_oe_n)));

   // R8
   addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs1_n && $past(!mem_cs1_n)) |-> $stable(mem_addr));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: tb/sram_ctl_bench.sv
module sram_ctl_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_f = 1'b0, req_s = 1'b0, wr = 1'b0, ret_f = 1'b0;
   logic [16:0] addr = '0;
   logic [7:0]  wdata = '0;

   logic        f_done, f_cs1_n, f_cs2, f_we_n, f_oe_n, f_dq_oe;
   logic [7:0]  f_rdata, f_dq_out, f_dq_in;
   logic [16:0] f_addr;
   logic        s_done, s_cs1_n, s_cs2, s_we_n, s_oe_n, s_dq_oe;
   logic [7:0]  s_rdata, s_dq_out, s_dq_in;
   logic [16:0] s_addr;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_ctl #(.CLK_NS(CLK_PERIOD), .FAST_GRADE(1'b1)) u_sram_ctl (
      .clk(clk), .rst_n(rst_n), .req(req_f), .wr(wr), .addr(addr), .wdata(wdata),
      .retain(ret_f), .done(f_done), .rdata(f_rdata), .mem_addr(f_addr),
      .mem_cs1_n(f_cs1_n), .mem_cs2(f_cs2), .mem_we_n(f_we_n), .mem_oe_n(f_oe_n),
      .mem_dq_out(f_dq_out), .mem_dq_in(f_dq_in), .mem_dq_oe(f_dq_oe));

   sram_ctl #(.CLK_NS(CLK_PERIOD), .FAST_GRADE(1'b0)) u_sram_ctl_slow (
      .clk(clk), .rst_n(rst_n), .req(req_s), .wr(wr), .addr(addr), .wdata(wdata),
      .retain(1'b0), .done(s_done), .rdata(s_rdata), .mem_addr(s_addr),
      .mem_cs1_n(s_cs1_n), .mem_cs2(s_cs2), .mem_we_n(s_we_n), .mem_oe_n(s_oe_n),
      .mem_dq_out(s_dq_out), .mem_dq_in(s_dq_in), .mem_dq_oe(s_dq_oe));

   // behavioural RAM models, indexed by the low address nibble
   logic [7:0] mem_f [16];
   logic [7:0] mem_s [16];
   initial begin
      for (int i = 0; i < 16; i++) begin
         mem_f[i] = 8'h00;
         mem_s[i] = 8'h00;
      end
   end
   always @(negedge clk) begin
      if (!f_cs1_n && f_cs2 && !f_we_n) mem_f[f_addr[3:0]] <= f_dq_out;
      if (!s_cs1_n && s_cs2 && !s_we_n) mem_s[s_addr[3:0]] <= s_dq_out;
   end
   assign f_dq_in = (!f_cs1_n && f_cs2 && !f_oe_n) ? mem_f[f_addr[3:0]] : 8'hEE;
   assign s_dq_in = (!s_cs1_n && s_cs2 && !s_oe_n) ? mem_s[s_addr[3:0]] : 8'hEE;

   // monitors sampled at falling edges
   int f_we_run = 0, f_we_last = 0, f_oe_run = 0, f_oe_last = 0;
   int s_we_run = 0, s_we_last = 0, s_oe_run = 0, s_oe_last = 0;
   int f_gap = 100, f_gap_drive = 100, f_done_run = 0, f_done_max = 0;
   bit f_prev_sel = 0, f_prev_drv = 0, f_setup_ok = 1, f_sel_seen = 0;
   bit f_both_low = 0, f_drive_bad = 0;
   logic [16:0] f_addr_seen = '0;

   always @(negedge clk) begin
      if (!f_we_n) f_we_run++; else if (f_we_run != 0) begin f_we_last = f_we_run; f_we_run = 0; end
      if (!f_oe_n) f_oe_run++; else if (f_oe_run != 0) begin f_oe_last = f_oe_run; f_oe_run = 0; end
      if (!s_we_n) s_we_run++; else if (s_we_run != 0) begin s_we_last = s_we_run; s_we_run = 0; end
      if (!s_oe_n) s_oe_run++; else if (s_oe_run != 0) begin s_oe_last = s_oe_run; s_oe_run = 0; end
      if (!f_cs1_n && !f_prev_sel) begin
         f_setup_ok  = f_we_n && f_oe_n && f_cs2;
         f_addr_seen = f_addr;
      end
      if (!f_cs1_n) f_sel_seen = 1;
      f_prev_sel = !f_cs1_n;
      if (!f_oe_n) f_gap = 0; else if (f_gap < 100) f_gap++;
      if (f_dq_oe && !f_prev_drv) f_gap_drive = f_gap;
      f_prev_drv = f_dq_oe;
      if (!f_we_n && !f_oe_n) f_both_low = 1;
      if (f_dq_oe && (f_we_n || f_cs1_n || !f_cs2)) f_drive_bad = 1;
      if (f_done) begin
         f_done_run++;
         if (f_done_run > f_done_max) f_done_max = f_done_run;
      end else begin
         f_done_run = 0;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run_op(input bit w, input logic [16:0] a, input logic [7:0] d,
                         input bit use_s, output int nf, output int ns);
      bit gf, gs;
      int n;
      @(negedge clk);
      wr = w; addr = a; wdata = d;
      req_f = 1'b1; req_s = use_s;
      gf = 0; gs = !use_s; n = 0; nf = -1; ns = -1;
      while (!(gf && gs) && n < 200) begin
         @(negedge clk);
         n++;
         if (!gf && f_done) begin gf = 1; nf = n; req_f = 1'b0; end
         if (!gs && s_done) begin gs = 1; ns = n; req_s = 1'b0; end
      end
      req_f = 1'b0; req_s = 1'b0;
   endtask

   task automatic t_reset;
      @(negedge clk);
      check(f_cs1_n && !f_cs2 && f_we_n && f_oe_n && !f_dq_oe && !f_done, "R1 in reset",
            {f_cs1_n, f_cs2, f_we_n, f_oe_n, f_dq_oe, f_done}, 6'b101100);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(f_cs1_n && !f_cs2 && f_we_n && f_oe_n && !f_dq_oe && !f_done, "R1 after reset",
            {f_cs1_n, f_cs2, f_we_n, f_oe_n, f_dq_oe, f_done}, 6'b101100);
   endtask

   task automatic t_write_read;
      int nf, ns;
      run_op(1'b1, 17'h0A5A5, 8'h3C, 1'b1, nf, ns);
      check(nf == 6, "R2 write done edge", nf, 6);
      check(f_we_last == 3, "R2 write strobe cycles", f_we_last, 3);
      check(f_setup_ok, "R2 setup cycle strobes high", f_setup_ok, 1);
      check(ns == 7, "R6 slow write done edge", ns, 7);
      check(s_we_last == 4, "R6 slow write strobe cycles", s_we_last, 4);
      run_op(1'b0, 17'h0A5A5, 8'h00, 1'b1, nf, ns);
      check(nf == 6, "R3 read done edge", nf, 6);
      check(f_rdata == 8'h3C, "R3 read data", f_rdata, 8'h3C);
      check(f_oe_last == 3, "R3 enable low cycles", f_oe_last, 3);
      check(ns == 8, "R6 slow read done edge", ns, 8);
      check(s_oe_last == 5, "R6 slow enable low cycles", s_oe_last, 5);
      check(s_rdata == 8'h3C, "R6 slow read data", s_rdata, 8'h3C);
   endtask

   task automatic t_patterns;
      int nf, ns;
      logic [16:0] al [4];
      logic [7:0]  dl [4];
      al[0] = 17'h00000; al[1] = 17'h1FFFF; al[2] = 17'h15552; al[3] = 17'h0A5A7;
      dl[0] = 8'hFF;     dl[1] = 8'h00;     dl[2] = 8'hA5;     dl[3] = 8'h5A;
      for (int i = 0; i < 4; i++) begin
         run_op(1'b1, al[i], dl[i], 1'b0, nf, ns);
         check(f_addr_seen == al[i], "R8 address on RAM pins", f_addr_seen, al[i]);
      end
      for (int i = 3; i >= 0; i--) begin
         run_op(1'b0, al[i], 8'h00, 1'b0, nf, ns);
         check(f_rdata == dl[i], "R3 read back pattern", f_rdata, dl[i]);
         check(f_addr_seen == al[i], "R8 read address on RAM pins", f_addr_seen, al[i]);
      end
      run_op(1'b1, 17'h00003, 8'h77, 1'b0, nf, ns);
      check(f_rdata == dl[0], "R3 rdata held across write", f_rdata, dl[0]);
   endtask

   task automatic t_turnaround;
      int nf, ns;
      run_op(1'b0, 17'h00003, 8'h00, 1'b0, nf, ns);
      check(f_rdata == 8'h77, "R3 read before write", f_rdata, 8'h77);
      run_op(1'b1, 17'h00004, 8'h99, 1'b0, nf, ns);
      check(f_gap_drive > 2, "R5 idle cycles before drive", f_gap_drive, 3);
      check(nf == 6, "R2 write after read", nf, 6);
   endtask

   task automatic t_retention;
      int n;
      @(negedge clk);
      ret_f = 1'b1; req_f = 1'b1; wr = 1'b0; addr = 17'h00004;
      f_sel_seen = 0;
      n = 0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (f_done) n++;
      end
      check(!f_sel_seen, "R7 no select during retention", f_sel_seen, 0);
      check(n == 0, "R7 request stalled", n, 0);
      check(f_cs1_n && !f_cs2 && f_oe_n, "R7 retention pin state",
            {f_cs1_n, f_cs2, f_oe_n}, 3'b101);
      ret_f = 1'b0;
      n = 0;
      while (f_cs1_n && n < 50) begin
         @(negedge clk);
         n++;
      end
      check(n == 5, "R7 recovery edges to select", n, 5);
      n = 0;
      while (!f_done && n < 50) begin
         @(negedge clk);
         n++;
      end
      req_f = 1'b0;
      check(f_rdata == 8'h99, "R7 read after recovery", f_rdata, 8'h99);
   endtask

   task automatic t_monitors;
      repeat (3) @(negedge clk);
      check(!f_both_low, "R4 strobes never both low", f_both_low, 0);
      check(!f_drive_bad, "R4 drive only while writing", f_drive_bad, 0);
      check(f_done_max == 1, "R9 done single cycle", f_done_max, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      bad++;
      total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_write_read();
      t_patterns();
      t_turnaround();
      t_retention();
      t_monitors();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule